// File: doc/BRIEF.md
# PLL fast-lock bandwidth sequencer

This block sets the bandwidth mode of a fractional-N synthesizer loop. The loop normally runs in narrow bandwidth, which keeps phase noise and spurs within limits. A frequency-update strobe that arrives with a nonzero timeout puts the loop into wide bandwidth, so that it acquires the new frequency quickly. In wide mode the block drives the wide charge-pump current code and closes the loop-filter switches, so that the loop stays stable at the higher current. After a programmable number of reference periods it returns to narrow bandwidth.

The lock timer is advanced by the falling edges of the phase-detector reference, which arrives as a level sampled on the system clock. The comparison in the phase detector happens on the rising edge, so the mode switching takes place away from it. The reference passes through a two-flop synchronizer before its edges are detected. The controller has two states. BW_NARROW is the reset and resting state. BW_WIDE is the fast-lock state. The transitions are:

- START (BW_NARROW to BW_WIDE): an update strobe arrives with a nonzero timeout.
- RELOAD (BW_WIDE to BW_WIDE): an update strobe arrives with a nonzero timeout.
- ABORT (BW_WIDE to BW_NARROW): an update strobe arrives with a zero timeout.
- EXPIRE (BW_WIDE to BW_NARROW): the last falling-edge tick of the timeout is consumed.

Top module: `fastlock_seq`

## Requirements
- R1: During and after reset the block is in narrow mode: `busy_o`=0, `filt_sw_o`=0 and `cp_code_o` equals `narrow_code_i`.
- R2: An update strobe with a nonzero timeout that is sampled on a clock edge puts the block in wide mode from that edge onward: `busy_o`=1, `filt_sw_o`=1 and `cp_code_o`=`wide_code_i`.
- R3: The timer advances only on falling edges (1 to 0) of the synchronized reference. Rising edges and steady levels leave the mode unchanged.
- R4: With a timeout T of 1 to 1023, wide mode lasts for exactly T reference falling edges, and the block then returns to narrow mode.
- R5: A zero timeout skips wide mode. A zero-timeout strobe in narrow mode leaves the outputs unchanged, and a zero-timeout strobe in wide mode returns the block to narrow mode at the next edge.
- R6: An update strobe during wide mode reloads the timer with the present timeout, so T further falling edges are needed before narrow mode.
- R7: The current code and the filter-switch enable change in the same system-clock cycle. `filt_sw_o`=1 exactly when `cp_code_o` carries the wide code.
- R8: The reference passes through two synchronizer flops. A falling edge on `ref_lvl_i` that is sampled at clock edge k ends wide mode (when it is the last tick) at edge k+2, not earlier.
- R9: When an update strobe and a timer tick are consumed on the same edge, the strobe takes priority and the timer is reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_lvl_i | input | 1 | Phase-detector reference level, asynchronous to the system clock |
| upd_i | input | 1 | Frequency-update strobe, one cycle |
| timeout_i | input | TMO_W (10) | Wide-mode duration in reference periods; 0 skips wide mode |
| wide_code_i | input | CODE_W (4) | Charge-pump current code used in wide mode |
| narrow_code_i | input | CODE_W (4) | Charge-pump current code used in narrow mode |
| cp_code_o | output | CODE_W (4) | Charge-pump current code in use |
| filt_sw_o | output | 1 | Loop-filter switch enable |
| busy_o | output | 1 | High while in wide mode |

## Verification
The assertions check on every cycle that the mode is held after reset, that a nonzero-timeout strobe always enters wide mode, that a zero-timeout strobe never starts wide mode, that wide mode never ends without a strobe or a synchronized falling edge, and that the code and the filter enable switch together. The exact length of wide mode is shown only by the bench scenarios: it counts T falling edges, reloads on a strobe in wide mode, lets a strobe win over a coinciding tick, and gives the three-edge latency through the synchronizer.

// File: rtl/fastlock_pkg.sv
package fastlock_pkg;
    typedef enum logic {
        BW_NARROW = 1'b0,
        BW_WIDE   = 1'b1
    } bw_state_e;
endpackage

// File: rtl/fl_ref_sync.sv
// Synchronizes the reference level and flags its falling edges.
module fl_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ref_lvl_i,
    output logic fall_tick_o
);
    localparam int TOP = STAGES;

    logic [TOP:0] shift_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[TOP-1:0], ref_lvl_i};
        end
    end

    // the last stage is a history copy of the synchronized level
    assign fall_tick_o = shift_q[TOP] & ~shift_q[TOP-1];
endmodule

// File: rtl/fl_tick_timer.sv
// Down counter of reference ticks, loaded on an update strobe.
module fl_tick_timer #(
    parameter int W = 10
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         tick_i,
    output logic         last_tick_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] count_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= load_val_i;
        end else if (tick_i && (count_q != '0)) begin
            count_q <= count_q - ONE;
        end
    end

    assign last_tick_o = tick_i && (count_q == ONE);
endmodule

// File: rtl/fl_mode_fsm.sv
// Narrow/wide bandwidth mode controller.
module fl_mode_fsm
    import fastlock_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              upd_i,
    input  logic              tmo_zero_i,
    input  logic              last_tick_i,
    input  logic [CODE_W-1:0] wide_code_i,
    input  logic [CODE_W-1:0] narrow_code_i,
    output logic              load_o,
    output logic [CODE_W-1:0] cp_code_o,
    output logic              filt_sw_o,
    output logic              busy_o
);
    bw_state_e state_q;
    bw_state_e state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= BW_NARROW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BW_NARROW: begin
                if (upd_i && !tmo_zero_i) begin
                    state_d = BW_WIDE;             // START
                end
            end
            BW_WIDE: begin
                if (upd_i) begin
                    state_d = tmo_zero_i ? BW_NARROW : BW_WIDE;  // ABORT / RELOAD
                end else if (last_tick_i) begin
                    state_d = BW_NARROW;           // EXPIRE
                end
            end
            default: state_d = BW_NARROW;
        endcase
    end

    always_comb begin
        load_o = upd_i;
        unique case (state_q)
            BW_WIDE: begin
                cp_code_o = wide_code_i;
                filt_sw_o = 1'b1;
                busy_o    = 1'b1;
            end
            default: begin
                cp_code_o = narrow_code_i;
                filt_sw_o = 1'b0;
                busy_o    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fastlock_seq.sv
module fastlock_seq #(
    parameter int TMO_W       = 10,
    parameter int CODE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ref_lvl_i,
    input  logic              upd_i,
    input  logic [TMO_W-1:0]  timeout_i,
    input  logic [CODE_W-1:0] wide_code_i,
    input  logic [CODE_W-1:0] narrow_code_i,
    output logic [CODE_W-1:0] cp_code_o,
    output logic              filt_sw_o,
    output logic              busy_o
);
    logic fall_tick;
    logic last_tick;
    logic load;

    fl_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ref_lvl_i  (ref_lvl_i),
        .fall_tick_o(fall_tick)
    );

    fl_tick_timer #(.W(TMO_W)) u_timer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (load),
        .load_val_i (timeout_i),
        .tick_i     (fall_tick),
        .last_tick_o(last_tick)
    );

    fl_mode_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .upd_i        (upd_i),
        .tmo_zero_i   (timeout_i == '0),
        .last_tick_i  (last_tick),
        .wide_code_i  (wide_code_i),
        .narrow_code_i(narrow_code_i),
        .load_o       (load),
        .cp_code_o    (cp_code_o),
        .filt_sw_o    (filt_sw_o),
        .busy_o       (busy_o)
    );
endmodule

// File: rtl/fastlock_seq_chk.sv
module fastlock_seq_chk #(
    parameter int TMO_W  = 10,
    parameter int CODE_W = 4
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              ref_lvl_i,
    input logic              upd_i,
    input logic [TMO_W-1:0]  timeout_i,
    input logic [CODE_W-1:0] wide_code_i,
    input logic [CODE_W-1:0] narrow_code_i,
    input logic [CODE_W-1:0] cp_code_o,
    input logic              filt_sw_o,
    input logic              busy_o
);
    // independent observer of the reference after a two-flop delay
    logic [2:0] obs_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) obs_q <= '0;
        else       obs_q <= {obs_q[1:0], ref_lvl_i};
    end

    AST_RESET_NARROW: assert property (@(posedge clk_i)
        rst_i |=> (!busy_o && !filt_sw_o)); // R1

    AST_UPD_ENTERS_WIDE: assert property (@(posedge clk_i) disable iff (rst_i)
        (upd_i && timeout_i != '0) |=> busy_o); // R2

    AST_HOLD_WITHOUT_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !upd_i && !(obs_q[2] && !obs_q[1])) |=> busy_o); // R3

    AST_ZERO_SKIPS_WIDE: assert property (@(posedge clk_i) disable iff (rst_i)
        (upd_i && timeout_i == '0) |=> !busy_o); // R5

    AST_SWITCH_TOGETHER: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(filt_sw_o) |-> (busy_o && cp_code_o == wide_code_i)); // R7

    AST_RELEASE_TOGETHER: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(filt_sw_o) |-> (!busy_o && cp_code_o == narrow_code_i)); // R7
endmodule

bind fastlock_seq fastlock_seq_chk #(.TMO_W(TMO_W), .CODE_W(CODE_W)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .ref_lvl_i    (ref_lvl_i),
    .upd_i        (upd_i),
    .timeout_i    (timeout_i),
    .wide_code_i  (wide_code_i),
    .narrow_code_i(narrow_code_i),
    .cp_code_o    (cp_code_o),
    .filt_sw_o    (filt_sw_o),
    .busy_o       (busy_o)
);

// File: tb/sim_fastlock_seq.sv
`timescale 1ns/1ps
module sim_fastlock_seq;
    localparam int TMO_W  = 10;
    localparam int CODE_W = 4;
    localparam int NVEC   = 4;
    // vector: {timeout, wide code, narrow code}
    localparam logic [TMO_W+2*CODE_W-1:0] VECS [NVEC] = '{
        {10'd3, 4'hC, 4'h2},
        {10'd1, 4'hF, 4'h0},
        {10'd5, 4'h8, 4'h1},
        {10'd2, 4'hA, 4'h5}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_lvl = 1'b1;
    logic upd = 1'b0;
    logic [TMO_W-1:0] tmo = '0;
    logic [CODE_W-1:0] wcode = 4'hC;
    logic [CODE_W-1:0] ncode = 4'h2;
    logic [CODE_W-1:0] cp_code;
    logic filt_sw;
    logic busy;
    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    fastlock_seq u0 (
        .clk_i(clk), .rst_i(rst), .ref_lvl_i(ref_lvl), .upd_i(upd),
        .timeout_i(tmo), .wide_code_i(wcode), .narrow_code_i(ncode),
        .cp_code_o(cp_code), .filt_sw_o(filt_sw), .busy_o(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // checks busy, filter enable and code all at once against the expected mode
    task automatic check_mode(input string req, input logic wide);
        check(req, {27'd0, busy, filt_sw, cp_code},
              {27'd0, wide, wide, wide ? wcode : ncode});
    endtask

    task automatic strobe(input logic [TMO_W-1:0] t);
        @(negedge clk);
        tmo = t;
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    // one reference period: 4 clocks high, 4 clocks low; the tick is consumed inside
    task automatic ref_period();
        ref_lvl = 1'b1;
        repeat (4) @(negedge clk);
        ref_lvl = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_mode("R1 in reset", 1'b0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_mode("R1 after reset", 1'b0);

        // table walk: R2 entry, R3/R4 count of falling edges, R7 together
        for (int v = 0; v < NVEC; v++) begin
            logic [TMO_W-1:0] t;
            t = VECS[v][TMO_W+2*CODE_W-1:2*CODE_W];
            wcode = VECS[v][2*CODE_W-1:CODE_W];
            ncode = VECS[v][CODE_W-1:0];
            strobe(t);
            check_mode("R2 enter wide", 1'b1);
            for (int k = 1; k <= int'(t); k++) begin
                ref_lvl = 1'b1;
                repeat (4) @(negedge clk);
                check_mode("R3 rising edge ignored", 1'b1);
                ref_lvl = 1'b0;
                repeat (4) @(negedge clk);
                check_mode("R4 fall count", k < int'(t));
            end
            check(v == 0 ? "R7 code narrow" : "R4 narrow", {28'd0, cp_code}, {28'd0, ncode});
        end

        // R5: zero timeout in narrow mode is ignored
        ref_lvl = 1'b1;
        strobe(10'd0);
        check_mode("R5 zero in narrow", 1'b0);
        // R5: zero timeout in wide mode aborts
        strobe(10'd5);
        check_mode("R5 setup wide", 1'b1);
        strobe(10'd0);
        check_mode("R5 zero aborts wide", 1'b0);

        // R6: strobe in wide mode reloads the timer
        strobe(10'd3);
        ref_period();
        check_mode("R6 after first fall", 1'b1);
        strobe(10'd3);
        ref_period();
        ref_period();
        check_mode("R6 reloaded, two falls", 1'b1);
        ref_period();
        check_mode("R6 reloaded, third fall", 1'b0);

        // R8: two-flop synchronizer latency
        ref_lvl = 1'b1;
        strobe(10'd1);
        repeat (4) @(negedge clk);
        ref_lvl = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check_mode("R8 still wide after two edges", 1'b1);
        @(negedge clk);
        check_mode("R8 narrow at third edge", 1'b0);

        // R9: strobe wins over a coinciding tick
        ref_lvl = 1'b1;
        repeat (4) @(negedge clk);
        strobe(10'd2);
        ref_period();
        check_mode("R9 one fall left", 1'b1);
        ref_lvl = 1'b1;
        repeat (4) @(negedge clk);
        ref_lvl = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        check_mode("R9 strobe beats tick", 1'b1);
        repeat (3) @(negedge clk);
        ref_period();
        check_mode("R9 reload needs two falls", 1'b1);
        ref_period();
        check_mode("R9 done", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule